// File: doc/BRIEF.md
# Per-Channel Line Statistics Counters

This block keeps traffic and error statistics for a multi-channel cell-based line interface. Each channel holds four live counters. One counts received line codes that are not valid symbols. One counts transmitted cells. One counts received cells that carry user traffic. One counts received cells whose header check failed. Event strobes come from the line decoder and from the cell delineation logic of each channel. Both of those sources are outside this block.

Software reads the counters over a synchronous byte-wide host bus, and every read takes a snapshot and then clears. Software first writes a single bit into the channel's select register. In that same clock cycle, the chosen live counter is copied into a 16-bit holding pair and the live counter is cleared. Software then reads the low and high bytes of the pair. To sample again, software writes the select register again. Counters saturate instead of wrapping, so a count that has reached its maximum shows that a gross fault is present.

Top module: `line_stats`

## Requirements
- R1: After reset, every live counter and every holding pair is zero, and `rd_data` is zero.
- R2: The symbol counter of channel c (8 bits by default) increases by one in each cycle where `sym_err[c]` is high.
- R3: The transmit counter of channel c (16 bits by default) increases by one in each cycle where `tx_cell[c]` is high.
- R4: The receive counter of channel c (16 bits by default) increases by one in each cycle where `rx_cell[c]` is high and both `rx_idle[c]` and `rx_hec_err[c]` are low.
- R5: The header-error counter of channel c (5 bits by default) increases by one in each cycle where `rx_cell[c]` and `rx_hec_err[c]` are both high, whatever the value of `rx_idle[c]`.
- R6: Channel c owns three addresses. Address 16*c+4 holds the low byte of the holding pair, 16*c+5 holds the high byte, and 16*c+6 is the select register. A read strobe at an edge returns the addressed byte on `rd_data` in the following cycle. In every other cycle `rd_data` is zero.
- R7: A write of 0x01, 0x02, 0x04 or 0x08 to the select register picks the symbol, transmit, receive or header-error counter of that channel, in that order. The write copies the counter's value, zero-extended to 16 bits, into the holding pair, and clears that counter.
- R8: A write of any other value to a select register is ignored. The holding pair and the counters stay unchanged.
- R9: Each counter stops at its all-ones value. Further events do not wrap it.
- R10: If an event for a counter arrives in the same cycle as the snapshot of that counter, the counter restarts at 1.
- R11: A read returns zero when the address is a select register, any offset other than 4 or 5, or a channel number of NCH or higher.
- R12: Events and select writes on one channel do not change any counter or holding pair of another channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_err | input | NCH | Invalid line symbol strobe, one bit per channel |
| tx_cell | input | NCH | Cell transmitted strobe |
| rx_cell | input | NCH | Cell received strobe |
| rx_idle | input | NCH | Qualifier: the received cell is an idle cell |
| rx_hec_err | input | NCH | Qualifier: the received cell failed its header check |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 8 | Host address: channel in [7:4], offset in [3:0] |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Host read data, registered |

## Verification
A wrong live count only becomes visible at the ports after a select write and two byte reads. Each such error therefore appears three host transactions after the write that exposes it. A counter that is not cleared by a snapshot, or that fails to restart at 1, shows up only at the next snapshot of the same counter. The bench follows every snapshot with a second one for this reason. A faulty decode of an ignored select write can corrupt the holding pair at once, which an immediate reread exposes. A faulty decode can also clear a counter without being seen, which the next valid snapshot exposes. Saturation faults show only after enough events to reach the maximum, so the bench drives the narrow counters past their limits.

// File: rtl/stat_pkg.sv
package stat_pkg;
   localparam int HOLD_W   = 16;
   localparam int KINDS    = 4;
   localparam logic [3:0] OFS_LO  = 4'h4;
   localparam logic [3:0] OFS_HI  = 4'h5;
   localparam logic [3:0] OFS_SEL = 4'h6;

   typedef enum logic [1:0] {
      K_SYM = 2'd0,
      K_TX  = 2'd1,
      K_RX  = 2'd2,
      K_HEC = 2'd3
   } kind_e;

   // true when exactly one of the four counter bits is set and the rest are clear
   function automatic logic sel_valid(input logic [7:0] v);
      int ones;
      ones = 0;
      for (int i = 0; i < KINDS; i++) ones += int'(v[i]);
      return (ones == 1) && (v[7:KINDS] == '0);
   endfunction
endpackage

// File: rtl/sat_counter.sv
module sat_counter #(
   parameter int W        = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         clr,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] MAXV = {W{1'b1}};
   localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

   logic [W-1:0] nxt;

   generate
      if (SATURATE) begin : g_sat
         always_comb begin
            if (clr)                     nxt = inc ? ONE : '0;
            else if (inc && q != MAXV)   nxt = q + ONE;
            else                         nxt = q;
         end
      end else begin : g_wrap
         always_comb begin
            if (clr)      nxt = inc ? ONE : '0;
            else if (inc) nxt = q + ONE;
            else          nxt = q;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end
endmodule

// File: rtl/chan_stats.sv
module chan_stats
   import stat_pkg::*;
#(
   parameter int SYM_W    = 8,
   parameter int TX_W     = 16,
   parameter int RX_W     = 16,
   parameter int HEC_W    = 5,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sym_err,
   input  logic              tx_cell,
   input  logic              rx_cell,
   input  logic              rx_idle,
   input  logic              rx_hec_err,
   input  logic              sel_wr,
   input  logic [7:0]        sel_data,
   output logic [HOLD_W-1:0] hold,
   output logic [HOLD_W-1:0] cnt_sym,
   output logic [HOLD_W-1:0] cnt_hec
);
   localparam int KW [KINDS] = '{SYM_W, TX_W, RX_W, HEC_W};

   logic [KINDS-1:0]  inc;
   logic [KINDS-1:0]  clr;
   logic [HOLD_W-1:0] cnt [KINDS];
   logic [HOLD_W-1:0] pick;
   logic              snap;

   assign inc[K_SYM] = sym_err;
   assign inc[K_TX]  = tx_cell;
   assign inc[K_RX]  = rx_cell & ~rx_idle & ~rx_hec_err;
   assign inc[K_HEC] = rx_cell & rx_hec_err;

   assign snap = sel_wr & sel_valid(sel_data);

   genvar k;
   generate
      for (k = 0; k < KINDS; k++) begin : g_kind
         assign clr[k] = snap & sel_data[k];
         sat_counter #(.W(KW[k]), .SATURATE(SATURATE)) u_cnt (
            .clk  (clk),
            .rst_n(rst_n),
            .inc  (inc[k]),
            .clr  (clr[k]),
            .q    (cnt[k][KW[k]-1:0])
         );
         if (KW[k] < HOLD_W) begin : g_pad
            assign cnt[k][HOLD_W-1:KW[k]] = '0;
         end
      end
   endgenerate

   always_comb begin
      pick = '0;
      for (int i = 0; i < KINDS; i++)
         if (sel_data[i]) pick = pick | cnt[i];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    hold <= '0;
      else if (snap) hold <= pick;
   end

   assign cnt_sym = cnt[K_SYM];
   assign cnt_hec = cnt[K_HEC];
endmodule

// File: rtl/host_port.sv
module host_port
   import stat_pkg::*;
#(
   parameter int NCH = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic                  rd_en,
   input  logic [7:0]            addr,
   input  logic [NCH*HOLD_W-1:0] hold_all,
   output logic [NCH-1:0]        sel_wr,
   output logic [7:0]            rd_data
);
   logic [3:0] ch;
   logic [3:0] ofs;
   logic [7:0] rd_mux;

   assign ch  = addr[7:4];
   assign ofs = addr[3:0];

   genvar c;
   generate
      for (c = 0; c < NCH; c++) begin : g_dec
         assign sel_wr[c] = wr_en && (ch == 4'(c)) && (ofs == OFS_SEL);
      end
   endgenerate

   always_comb begin
      rd_mux = '0;
      for (int i = 0; i < NCH; i++) begin
         if (ch == 4'(i)) begin
            if (ofs == OFS_LO) rd_mux = hold_all[i*HOLD_W +: 8];
            if (ofs == OFS_HI) rd_mux = hold_all[i*HOLD_W+8 +: 8];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rd_data <= '0;
      else        rd_data <= rd_en ? rd_mux : 8'h00;
   end
endmodule

// File: rtl/line_stats.sv
module line_stats
   import stat_pkg::*;
#(
   parameter int NCH      = 4,
   parameter int SYM_W    = 8,
   parameter int TX_W     = 16,
   parameter int RX_W     = 16,
   parameter int HEC_W    = 5,
   parameter bit SATURATE = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] sym_err,
   input  logic [NCH-1:0] tx_cell,
   input  logic [NCH-1:0] rx_cell,
   input  logic [NCH-1:0] rx_idle,
   input  logic [NCH-1:0] rx_hec_err,
   input  logic           wr_en,
   input  logic           rd_en,
   input  logic [7:0]     addr,
   input  logic [7:0]     wr_data,
   output logic [7:0]     rd_data
);
   generate
      if (NCH < 1 || NCH > 16) begin : g_bad_nch
         $error("line_stats: NCH must be 1..16");
      end
      if (SYM_W < 1 || SYM_W > HOLD_W || TX_W < 1 || TX_W > HOLD_W ||
          RX_W < 1 || RX_W > HOLD_W || HEC_W < 1 || HEC_W > HOLD_W) begin : g_bad_w
         $error("line_stats: counter widths must be 1..16");
      end
   endgenerate

   logic [NCH-1:0]        sel_wr;
   logic [NCH*HOLD_W-1:0] hold_all;
   logic [NCH*HOLD_W-1:0] cnt_sym_all;
   logic [NCH*HOLD_W-1:0] cnt_hec_all;

   host_port #(.NCH(NCH)) u_host (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .rd_en   (rd_en),
      .addr    (addr),
      .hold_all(hold_all),
      .sel_wr  (sel_wr),
      .rd_data (rd_data)
   );

   genvar c;
   generate
      for (c = 0; c < NCH; c++) begin : g_ch
         chan_stats #(
            .SYM_W(SYM_W), .TX_W(TX_W), .RX_W(RX_W), .HEC_W(HEC_W),
            .SATURATE(SATURATE)
         ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .sym_err   (sym_err[c]),
            .tx_cell   (tx_cell[c]),
            .rx_cell   (rx_cell[c]),
            .rx_idle   (rx_idle[c]),
            .rx_hec_err(rx_hec_err[c]),
            .sel_wr    (sel_wr[c]),
            .sel_data  (wr_data),
            .hold      (hold_all[c*HOLD_W +: HOLD_W]),
            .cnt_sym   (cnt_sym_all[c*HOLD_W +: HOLD_W]),
            .cnt_hec   (cnt_hec_all[c*HOLD_W +: HOLD_W])
         );
      end
   endgenerate
endmodule

// File: rtl/line_stats_chk.sv
module line_stats_chk
   import stat_pkg::*;
#(
   parameter int NCH      = 4,
   parameter int HEC_W    = 5,
   parameter bit SATURATE = 1'b1
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [NCH-1:0]        sym_err,
   input logic                  wr_en,
   input logic                  rd_en,
   input logic [7:0]            addr,
   input logic [7:0]            wr_data,
   input logic [7:0]            rd_data,
   input logic [NCH*HOLD_W-1:0] hold_all,
   input logic [NCH*HOLD_W-1:0] cnt_sym_all,
   input logic [NCH*HOLD_W-1:0] cnt_hec_all
);
   localparam logic [HOLD_W-1:0] HEC_MAX = HOLD_W'((1 << HEC_W) - 1);

   // R6: no read strobe, no data
   p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> rd_data == 8'h00);

   // R11: offsets other than the byte pair always read zero
   p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr[3:0] != OFS_LO && addr[3:0] != OFS_HI) |=> rd_data == 8'h00);

   genvar c;
   generate
      for (c = 0; c < NCH; c++) begin : g_ch
         logic [7:0] sel_addr;
         assign sel_addr = {4'(c), OFS_SEL};

         // R7: snapshot of the symbol counter lands in the holding pair
         p_snap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == sel_addr && wr_data == 8'h01)
            |=> hold_all[c*HOLD_W +: HOLD_W] == $past(cnt_sym_all[c*HOLD_W +: HOLD_W]));

         // R10: counter restarts at the coincident event, else zero
         p_snap_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == sel_addr && wr_data == 8'h01)
            |=> cnt_sym_all[c*HOLD_W +: HOLD_W] == {15'd0, $past(sym_err[c])});

         // R8: select values with zero or several bits leave the pair alone
         p_bad_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == sel_addr && $countones(wr_data) != 1)
            |=> $stable(hold_all[c*HOLD_W +: HOLD_W]));

         if (SATURATE) begin : g_sat
            // R9: a full header-error counter stays full
            p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
               (cnt_hec_all[c*HOLD_W +: HOLD_W] == HEC_MAX &&
                !(wr_en && addr == sel_addr && wr_data == 8'h08))
               |=> cnt_hec_all[c*HOLD_W +: HOLD_W] == HEC_MAX);
         end
      end
   endgenerate
endmodule

bind line_stats line_stats_chk #(.NCH(NCH), .HEC_W(HEC_W), .SATURATE(SATURATE)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sym_err    (sym_err),
   .wr_en      (wr_en),
   .rd_en      (rd_en),
   .addr       (addr),
   .wr_data    (wr_data),
   .rd_data    (rd_data),
   .hold_all   (hold_all),
   .cnt_sym_all(cnt_sym_all),
   .cnt_hec_all(cnt_hec_all)
);

// File: tb/tb_line_stats.sv
module tb_line_stats;
   localparam int NCH = 4;
   localparam int NV  = 12;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NCH-1:0] sym_err = '0, tx_cell = '0, rx_cell = '0, rx_idle = '0, rx_hec_err = '0;
   logic           wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0]     addr = '0, wr_data = '0;
   logic [7:0]     rd_data;

   int  tests = 0;
   int  fails = 0;
   bit  done  = 1'b0;

   always #10 clk = ~clk;

   line_stats #(.NCH(NCH)) dut (
      .clk(clk), .rst_n(rst_n), .sym_err(sym_err), .tx_cell(tx_cell),
      .rx_cell(rx_cell), .rx_idle(rx_idle), .rx_hec_err(rx_hec_err),
      .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data)
   );

   // vector: ch[35:34] pattern[33:31] count[30:20] select[19:16] expected[15:0]
   // pattern: 0 symbol, 1 tx, 2 good rx, 3 idle rx, 4 hec rx, 5 idle+hec rx
   localparam logic [35:0] VEC [NV] = '{
      {2'd0, 3'd0, 11'd7,    4'h1, 16'd7},    // R2
      {2'd1, 3'd1, 11'd200,  4'h2, 16'd200},  // R3
      {2'd2, 3'd2, 11'd33,   4'h4, 16'd33},   // R4
      {2'd3, 3'd4, 11'd12,   4'h8, 16'd12},   // R5
      {2'd0, 3'd4, 11'd9,    4'h4, 16'd0},    // R4 hec excluded
      {2'd1, 3'd3, 11'd20,   4'h4, 16'd0},    // R4 idle excluded
      {2'd2, 3'd3, 11'd6,    4'h8, 16'd0},    // R5 idle no hec
      {2'd3, 3'd5, 11'd4,    4'h8, 16'd4},    // R5 idle+hec counts
      {2'd0, 3'd0, 11'd300,  4'h1, 16'd255},  // R9 8-bit
      {2'd1, 3'd4, 11'd40,   4'h8, 16'd31},   // R9 5-bit
      {2'd2, 3'd1, 11'd1000, 4'h2, 16'd1000}, // R3 high byte
      {2'd3, 3'd2, 11'd257,  4'h4, 16'd257}   // R4 high byte
   };

   task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic clear_strobes();
      sym_err = '0; tx_cell = '0; rx_cell = '0; rx_idle = '0; rx_hec_err = '0;
   endtask

   task automatic drive(input int ch, input int pat, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         clear_strobes();
         case (pat)
            0: sym_err[ch] = 1'b1;
            1: tx_cell[ch] = 1'b1;
            2: rx_cell[ch] = 1'b1;
            3: begin rx_cell[ch] = 1'b1; rx_idle[ch] = 1'b1; end
            4: begin rx_cell[ch] = 1'b1; rx_hec_err[ch] = 1'b1; end
            default: begin rx_cell[ch] = 1'b1; rx_idle[ch] = 1'b1; rx_hec_err[ch] = 1'b1; end
         endcase
      end
      @(negedge clk);
      clear_strobes();
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [7:0] v);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      v = rd_data;
   endtask

   task automatic read_hold(input int ch, output logic [15:0] v);
      logic [7:0] lo, hi;
      bus_read(8'(ch * 16 + 4), lo);
      bus_read(8'(ch * 16 + 5), hi);
      v = {hi, lo};
   endtask

   task automatic snap_read(input int ch, input logic [7:0] sel, output logic [15:0] v);
      bus_write(8'(ch * 16 + 6), sel);
      read_hold(ch, v);
   endtask

   task automatic clear_chan(input int ch);
      for (int k = 0; k < 4; k++) bus_write(8'(ch * 16 + 6), 8'(1 << k));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      logic [7:0]  b;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      check("R1 rd_data", {8'd0, rd_data}, 16'd0);
      for (int ch = 0; ch < NCH; ch++) begin
         read_hold(ch, v);
         check("R1 hold", v, 16'd0);
      end
      snap_read(1, 8'h02, v);
      check("R1 tx counter", v, 16'd0);

      // table walk
      for (int i = 0; i < NV; i++) begin
         drive(int'(VEC[i][35:34]), int'(VEC[i][33:31]), int'(VEC[i][30:20]));
         snap_read(int'(VEC[i][35:34]), {4'h0, VEC[i][19:16]}, v);
         check($sformatf("R7 vector %0d", i), v, VEC[i][15:0]);
         clear_chan(int'(VEC[i][35:34]));
      end

      // R7: snapshot cleared the counter
      drive(0, 1, 5);
      snap_read(0, 8'h02, v);
      check("R7 first snapshot", v, 16'd5);
      snap_read(0, 8'h02, v);
      check("R7 cleared after snapshot", v, 16'd0);

      // R8: bad select values ignored
      drive(2, 0, 3);
      snap_read(2, 8'h01, v);
      check("R8 setup", v, 16'd3);
      drive(2, 0, 4);
      bus_write(8'h26, 8'h03);
      bus_write(8'h26, 8'h00);
      bus_write(8'h26, 8'h10);
      read_hold(2, v);
      check("R8 hold unchanged", v, 16'd3);
      snap_read(2, 8'h01, v);
      check("R8 counter not cleared", v, 16'd4);

      // R10: event coincident with snapshot
      drive(1, 0, 6);
      @(negedge clk);
      wr_en = 1'b1; addr = 8'h16; wr_data = 8'h01; sym_err[1] = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; sym_err[1] = 1'b0;
      read_hold(1, v);
      check("R10 snapshot value", v, 16'd6);
      snap_read(1, 8'h01, v);
      check("R10 restart at one", v, 16'd1);

      // R11: unmapped reads
      bus_read(8'h06, b);
      check("R11 select reads zero", {8'd0, b}, 16'd0);
      bus_read(8'h00, b);
      check("R11 offset 0", {8'd0, b}, 16'd0);
      drive(0, 1, 9);
      snap_read(0, 8'h02, v);
      bus_read(8'h44, b);
      check("R11 channel 4", {8'd0, b}, 16'd0);
      bus_read(8'h07, b);
      check("R11 offset 7", {8'd0, b}, 16'd0);

      // R6: rd_data returns to zero after the read cycle
      bus_read(8'h04, b);
      check("R6 low byte", {8'd0, b}, 16'd9);
      @(negedge clk);
      check("R6 idle zero", {8'd0, rd_data}, 16'd0);

      // R12: channel isolation
      drive(3, 1, 11);
      snap_read(2, 8'h02, v);
      check("R12 other channel tx", v, 16'd0);
      read_hold(0, v);
      check("R12 other channel hold", v, 16'd9);
      snap_read(3, 8'h02, v);
      check("R12 own channel tx", v, 16'd11);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule